// File: doc/BRIEF.md
# PWM Pair Output Override

This block sits between a paired-channel PWM generator and the output pins. Each pair holds an even channel (called n) and the odd channel above it (n+1). For every channel, software can replace the generated waveform with a fixed level. The block has several such pairs. Each pair has its own complementary-mode flag.

Software writes enable and level bits into a holding buffer. Nothing reaches the pins until a single-cycle sync pulse copies the whole buffer into the live settings. In complementary mode the block never drives both channels of a pair high. If both channels are forced and both requested levels are 1, channel n goes high and channel n+1 goes low. A channel whose enable is clear follows its generated waveform, whatever its level bit holds. Every output is registered, so the pins lag their inputs by one clock.

Top module: `pwm_force_unit`

## Requirements
- R1: Reset clears the buffered and live bits and drives every pin low. From the first clock after reset, each pin follows its generated input.
- R2: A channel whose live enable is 0 shows, on the pin after each clock edge, the generated level sampled at that edge.
- R3: A write changes only the buffer. The pins do not change, however many clocks pass, until a sync pulse arrives.
- R4: A sync pulse sampled at edge m loads the live bits at m. The pins show the new forcing only after edge m+1.
- R5: With complementary mode off and both enables of a pair live, channel n shows its level bit and channel n+1 shows its own. This holds for all four level combinations.
- R6: With complementary mode on and both enables live, the level pairs (n, n+1) = 00, 01 and 10 reach the pins unchanged.
- R7: With complementary mode on, both enables live and both levels 1, channel n is driven to 1 and channel n+1 to 0.
- R8: When only one enable of a pair is live, only that channel is forced. The other channel follows its generated waveform, in either mode, and the complementary rule of R7 does not apply.
- R9: The level bit of a channel whose live enable is 0 has no effect on its pin.
- R10: When a write and a sync pulse arrive in the same cycle, the sync loads the buffer contents from before that write. The written data waits in the buffer for the next sync.
- R11: Pairs are independent. The mode, enables and levels of one pair never affect another pair.
- R12: A forced level holds through any number of clocks, through changes of the generated waveform and through further writes, until a later sync pulse loads new bits.
- R13: Bit 2p of each channel vector is channel n of pair p and bit 2p+1 is channel n+1. Bit p of the mode vector selects complementary mode (1) for pair p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gen_i | input | 2*NUM_PAIRS | Generated waveform, one bit per channel |
| comp_i | input | NUM_PAIRS | Complementary-mode flag, one bit per pair |
| wr_i | input | 1 | Write strobe for the override buffer |
| wr_en_i | input | 2*NUM_PAIRS | Override-enable bits to buffer |
| wr_val_i | input | 2*NUM_PAIRS | Override-level bits to buffer |
| sync_i | input | 1 | Single-cycle pulse that copies the buffer into the live bits |
| pin_o | output | 2*NUM_PAIRS | Registered channel outputs |

## Verification
The hardest corner is a complementary pair asked to drive 11. A design that misses R7 drives both pins high, and one that applies the rule with a single enable changes a channel that should follow its waveform. The timing corners come next. A design that lets writes through without waiting for sync moves the pins early. A design that loads the buffer on the sync edge from the same-cycle write shows the new data one sync too soon. A design that skips the output register shows the forcing an edge early. Further checks toggle the waveform under forced and free channels with unused level bits set. These catch a design that leaks a level bit into a free channel or lets one pair's mode reach another.

// File: rtl/pwm_force_pkg.sv
package pwm_force_pkg;

    // Two bits of one pair: bit 0 is channel n, bit 1 is channel n+1.
    typedef logic [1:0] pair_bits_t;

    // How a pair is driven, decoded straight from its two live enables.
    typedef enum logic [1:0] {
        PAIR_FREE       = 2'b00,
        PAIR_FORCE_EVEN = 2'b01,
        PAIR_FORCE_ODD  = 2'b10,
        PAIR_FORCE_BOTH = 2'b11
    } pair_mode_e;

    function automatic pair_mode_e decode_mode(pair_bits_t en);
        return pair_mode_e'(en);
    endfunction

endpackage

// File: rtl/force_shadow_reg.sv
module force_shadow_reg #(
    parameter int unsigned CH = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_i,
    input  logic [CH-1:0] wr_en_i,
    input  logic [CH-1:0] wr_val_i,
    input  logic          sync_i,
    output logic [CH-1:0] buf_en_o,
    output logic [CH-1:0] buf_val_o,
    output logic [CH-1:0] act_en_o,
    output logic [CH-1:0] act_val_o
);

    typedef struct packed {
        logic [CH-1:0] buf_en;
        logic [CH-1:0] buf_val;
        logic [CH-1:0] act_en;
        logic [CH-1:0] act_val;
    } shadow_t;

    shadow_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // The live copy takes the buffer as it stood before this edge.
        if (sync_i) begin
            s_d.act_en  = s_q.buf_en;
            s_d.act_val = s_q.buf_val;
        end
        if (wr_i) begin
            s_d.buf_en  = wr_en_i;
            s_d.buf_val = wr_val_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign buf_en_o  = s_q.buf_en;
    assign buf_val_o = s_q.buf_val;
    assign act_en_o  = s_q.act_en;
    assign act_val_o = s_q.act_val;

endmodule

// File: rtl/force_pair_mux.sv
module force_pair_mux
    import pwm_force_pkg::*;
(
    input  pair_bits_t gen_i,
    input  logic       comp_i,
    input  pair_bits_t en_i,
    input  pair_bits_t val_i,
    output pair_bits_t pin_d_o
);

    pair_mode_e mode;

    always_comb begin
        mode = decode_mode(en_i);
        unique case (mode)
            PAIR_FREE:       pin_d_o = gen_i;
            PAIR_FORCE_EVEN: pin_d_o = {gen_i[1], val_i[0]};
            PAIR_FORCE_ODD:  pin_d_o = {val_i[1], gen_i[0]};
            PAIR_FORCE_BOTH: begin
                // Complementary pair must never have both pins high.
                if (comp_i && (val_i == 2'b11)) begin
                    pin_d_o = 2'b01;
                end else begin
                    pin_d_o = val_i;
                end
            end
            default:         pin_d_o = gen_i;
        endcase
    end

endmodule

// File: rtl/pwm_force_unit.sv
module pwm_force_unit
    import pwm_force_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = 4
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [2*NUM_PAIRS-1:0] gen_i,
    input  logic [NUM_PAIRS-1:0]   comp_i,
    input  logic                   wr_i,
    input  logic [2*NUM_PAIRS-1:0] wr_en_i,
    input  logic [2*NUM_PAIRS-1:0] wr_val_i,
    input  logic                   sync_i,
    output logic [2*NUM_PAIRS-1:0] pin_o
);

    localparam int unsigned CH = 2 * NUM_PAIRS;

    typedef struct packed {
        logic [CH-1:0] pin;
    } out_t;

    logic [CH-1:0] buf_en, buf_val, act_en, act_val;
    logic [CH-1:0] mux_pin;
    out_t          o_d, o_q;

    force_shadow_reg #(.CH(CH)) shadow_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (wr_i),
        .wr_en_i   (wr_en_i),
        .wr_val_i  (wr_val_i),
        .sync_i    (sync_i),
        .buf_en_o  (buf_en),
        .buf_val_o (buf_val),
        .act_en_o  (act_en),
        .act_val_o (act_val)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        force_pair_mux mux_i (
            .gen_i   (gen_i[2*p +: 2]),
            .comp_i  (comp_i[p]),
            .en_i    (act_en[2*p +: 2]),
            .val_i   (act_val[2*p +: 2]),
            .pin_d_o (mux_pin[2*p +: 2])
        );
    end

    always_comb begin
        o_d     = o_q;
        o_d.pin = mux_pin;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign pin_o = o_q.pin;

endmodule

// File: rtl/pwm_force_unit_chk.sv
module pwm_force_unit_chk #(
    parameter int unsigned NUM_PAIRS = 4
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic [2*NUM_PAIRS-1:0] gen_i,
    input logic [NUM_PAIRS-1:0]   comp_i,
    input logic                   sync_i,
    input logic [2*NUM_PAIRS-1:0] pin_o,
    input logic [2*NUM_PAIRS-1:0] buf_en,
    input logic [2*NUM_PAIRS-1:0] buf_val,
    input logic [2*NUM_PAIRS-1:0] act_en,
    input logic [2*NUM_PAIRS-1:0] act_val
);

    AST_LIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sync_i |=> ($stable(act_en) && $stable(act_val)));  // R12

    AST_SYNC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_i |=> (act_en == $past(buf_en) && act_val == $past(buf_val)));  // R4

    for (genvar c = 0; c < 2 * NUM_PAIRS; c++) begin : g_ch
        AST_FREE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(rst_ni) && !$past(act_en[c]) |-> pin_o[c] == $past(gen_i[c]));  // R2

        AST_PLAIN_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(rst_ni) && $past(act_en[c] && !comp_i[c/2])
            |-> pin_o[c] == $past(act_val[c]));  // R5
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pr
        AST_COMP_NOT_BOTH_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(rst_ni) && $past(comp_i[p] && act_en[2*p] && act_en[2*p+1]
                                   && act_val[2*p] && act_val[2*p+1])
            |-> (pin_o[2*p] && !pin_o[2*p+1]));  // R7
    end

endmodule

bind pwm_force_unit pwm_force_unit_chk #(.NUM_PAIRS(NUM_PAIRS)) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .gen_i   (gen_i),
    .comp_i  (comp_i),
    .sync_i  (sync_i),
    .pin_o   (pin_o),
    .buf_en  (buf_en),
    .buf_val (buf_val),
    .act_en  (act_en),
    .act_val (act_val)
);

// File: tb/pwm_force_unit_tb_top.sv
`timescale 1ns/1ps
module pwm_force_unit_tb_top;

    localparam int P  = 4;
    localparam int CH = 2 * P;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic [CH-1:0] gen_i = '0;
    logic [P-1:0]  comp_i = '0;
    logic          wr_i = 1'b0;
    logic [CH-1:0] wr_en_i = '0;
    logic [CH-1:0] wr_val_i = '0;
    logic          sync_i = 1'b0;
    logic [CH-1:0] pin_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk_i = ~clk_i;  // 250 MHz

    pwm_force_unit #(.NUM_PAIRS(P)) dut_i (
        .clk_i, .rst_ni, .gen_i, .comp_i, .wr_i,
        .wr_en_i, .wr_val_i, .sync_i, .pin_o
    );

    // Expected pins from the requirements (R2, R5-R9, R13).
    function automatic logic [CH-1:0] model(logic [CH-1:0] g, logic [P-1:0] cm,
                                            logic [CH-1:0] en, logic [CH-1:0] v);
        logic [CH-1:0] r;
        for (int p = 0; p < P; p++) begin
            r[2*p]   = en[2*p]   ? v[2*p]   : g[2*p];
            r[2*p+1] = en[2*p+1] ? v[2*p+1] : g[2*p+1];
            if (cm[p] && en[2*p] && en[2*p+1] && v[2*p] && v[2*p+1]) begin
                r[2*p]   = 1'b1;
                r[2*p+1] = 1'b0;
            end
        end
        return r;
    endfunction

    task automatic step();
        @(posedge clk_i);
        #1;
    endtask

    task automatic check(string tag, logic [CH-1:0] act, logic [CH-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: pin_o=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic write_buf(logic [CH-1:0] en, logic [CH-1:0] v);
        wr_i = 1'b1; wr_en_i = en; wr_val_i = v;
        step();
        wr_i = 1'b0;
    endtask

    task automatic do_sync();
        sync_i = 1'b1;
        step();
        sync_i = 1'b0;
    endtask

    // write, sync, then one edge for the output register
    task automatic load(logic [CH-1:0] en, logic [CH-1:0] v);
        write_buf(en, v);
        do_sync();
        step();
    endtask

    task automatic t_reset();
        check("R1 reset pins low", pin_o, '0);
        rst_ni = 1'b1;
        gen_i = 8'b1011_0110;
        step();
        check("R1 follow after reset", pin_o, 8'b1011_0110);
    endtask

    task automatic t_pass();
        load('0, '1);  // levels set, enables clear
        foreach (gen_i[i]) begin
            gen_i = 8'h01 << i;
            step();
            check("R2 R9 walking one free", pin_o, 8'h01 << i);
        end
        gen_i = 8'hA5; step();
        check("R9 level bits ignored", pin_o, 8'hA5);
    endtask

    task automatic t_write_then_sync();
        comp_i = '0; gen_i = 8'h00;
        write_buf('1, 8'hFF);
        step(); step(); step();
        check("R3 write without sync", pin_o, 8'h00);
        do_sync();
        check("R4 not yet at sync edge", pin_o, 8'h00);
        step();
        check("R4 forced one edge later", pin_o, 8'hFF);
    endtask

    task automatic t_plain();
        comp_i = '0;
        gen_i = 8'h5A;
        for (int k = 0; k < 4; k++) begin
            logic [CH-1:0] v = {P{k[1:0]}};
            load('1, v);
            check("R5 plain forced pair", pin_o, model(gen_i, comp_i, '1, v));
        end
    endtask

    task automatic t_comp();
        comp_i = '1;
        gen_i = 8'hC3;
        for (int k = 0; k < 3; k++) begin
            logic [CH-1:0] v = {P{k[1:0]}};
            load('1, v);
            check("R6 complementary direct", pin_o, {P{k[1:0]}});
        end
        load('1, '1);
        check("R7 complementary 11", pin_o, {P{2'b01}});
    endtask

    task automatic t_single();
        comp_i = '1;
        load({P{2'b01}}, '1);  // only channel n enabled, levels all 1
        gen_i = 8'hFF; step();
        check("R8 only even forced a", pin_o, 8'hFF);
        gen_i = 8'h00; step();
        check("R8 only even forced b", pin_o, {P{2'b01}});
        load({P{2'b10}}, '1);
        gen_i = 8'h00; step();
        check("R8 only odd forced", pin_o, {P{2'b10}});
        comp_i = '0;
        load({P{2'b10}}, '0);
        gen_i = 8'hFF; step();
        check("R8 only odd low plain", pin_o, {P{2'b01}});
    endtask

    task automatic t_same_cycle();
        comp_i = '0; gen_i = 8'h3C;
        load('0, '0);
        wr_i = 1'b1; wr_en_i = '1; wr_val_i = 8'h00; sync_i = 1'b1;
        step();
        wr_i = 1'b0; sync_i = 1'b0;
        step();
        check("R10 sync takes old buffer", pin_o, 8'h3C);
        do_sync(); step();
        check("R10 new data on next sync", pin_o, 8'h00);
    endtask

    task automatic t_pairs();
        logic [CH-1:0] en = 8'b11_01_11_00;
        logic [CH-1:0] v  = 8'b11_11_11_11;
        comp_i = 4'b0100; gen_i = 8'b00_10_00_10;
        load(en, v);
        check("R11 pairs independent", pin_o, model(gen_i, comp_i, en, v));
        comp_i = 4'b1001; step();
        check("R11 mode per pair", pin_o, model(gen_i, comp_i, en, v));
    endtask

    task automatic t_hold();
        comp_i = '0;
        load('1, 8'h96);
        write_buf('0, '0);
        for (int k = 0; k < 5; k++) begin
            gen_i = gen_i ^ 8'hFF; step();
        end
        check("R12 forcing holds", pin_o, 8'h96);
        do_sync(); step();
        check("R12 released by later sync", pin_o, gen_i);
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        t_pass();
        t_write_then_sync();
        t_plain();
        t_comp();
        t_single();
        t_same_cycle();
        t_pairs();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule